// File: doc/BRIEF.md
# RV64 Integer Multiply Unit

This unit computes the multiply results of the 64-bit RISC-V integer multiply instructions. A single shift-add datapath forms a 128-bit product from two 64-bit operands. From that product it returns either the low 64 bits or the high 64 bits. For the high half, the operands are treated as signed×signed, signed×unsigned or unsigned×unsigned. A 32-bit word form keeps the low 32 bits of the product and sign-extends them.

The surrounding pipeline pulses `start` for one cycle with the operation code and both operands. The unit copies these into internal registers, so the inputs may change on the next cycle. After a fixed latency it raises `done` for one cycle, with the destination value on `result`. `result` then keeps that value until the next completion. While an operation is running, further start pulses are dropped.

Signed forms work on magnitudes. The 128-bit product is negated at the end when exactly one of the operands treated as signed is negative.

Top module: `rv64_mul_unit`

## Requirements
- R1: Code 0 on `op` returns bits 63:0 of the product of the two operands; the value wraps and does not depend on signedness.
- R2: Code 1 treats both operands as two's complement and returns bits 127:64 of their 128-bit product.
- R3: Code 2 treats `src_a` as signed and `src_b` as unsigned and returns bits 127:64 of the product.
- R4: Code 3 treats both operands as unsigned and returns bits 127:64 of the product.
- R5: Code 4 multiplies bits 31:0 of each operand, keeps the low 32 bits of that product, and fills bits 63:32 of `result` with copies of bit 31.
- R6: Codes 5, 6 and 7 complete normally with a `result` of zero.
- R7: `done` is high for exactly one cycle, 65 clock edges after the edge that accepted the start (XLEN+1 for the default XLEN of 64).
- R8: A start pulse that arrives while an operation is in progress is ignored: neither the timing nor the value of the running operation changes, and no extra completion follows.
- R9: A synchronous active-high `rst` clears the busy state, `done` and `result`, and it aborts any operation in progress.
- R10: `result` changes only on the edge that raises `done`, and it holds its value between completions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin an operation |
| op | input | 3 | Operation code (0 low, 1 signed high, 2 signed-unsigned high, 3 unsigned high, 4 word) |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Destination value, held between completions |

## Verification
Every accepted start produces its result exactly 65 edges later: 64 shift-add steps followed by one cycle that negates the product and selects the half. The bench's reference model loads a countdown of 65 on the edge that accepts a start, and it raises its expected `done` and expected `result` on the edge where the countdown expires. The bench compares the model with the outputs at every falling edge, so a completion one cycle early or late is a mismatch on both `done` and `result`. Start pulses sent during the countdown are dropped by the model as well, so the model stays aligned with the design.

// File: rtl/rv64_mul_unit.sv
module rv64_mul_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [2:0]      op,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  output logic            done,
  output logic [XLEN-1:0] result
);
  localparam int PW   = 2 * XLEN;
  localparam int HW   = XLEN / 2;
  localparam int CW   = $clog2(XLEN + 1);
  localparam logic [CW-1:0] STEPS = CW'(XLEN);

  logic          busy;
  logic [CW-1:0] cnt;
  logic [PW-1:0] acc, ma;
  logic [XLEN-1:0] mb;
  logic          neg;
  logic [2:0]    op_q;

  wire a_sgn = (op == 3'd1) || (op == 3'd2);
  wire b_sgn = (op == 3'd1);
  wire word  = (op == 3'd4);
  wire a_neg = a_sgn & src_a[XLEN-1];
  wire b_neg = b_sgn & src_b[XLEN-1];
  wire [XLEN-1:0] a_abs = a_neg ? -src_a : src_a;
  wire [XLEN-1:0] b_abs = b_neg ? -src_b : src_b;

  wire [PW-1:0]   ld_a = word ? {{(PW-HW){1'b0}}, src_a[HW-1:0]} : {{XLEN{1'b0}}, a_abs};
  wire [XLEN-1:0] ld_b = word ? {{HW{1'b0}}, src_b[HW-1:0]} : b_abs;

  wire [PW-1:0] prod = neg ? -acc : acc;

  logic [XLEN-1:0] fin;
  always_comb begin
    case (op_q)
      3'd0:             fin = prod[XLEN-1:0];
      3'd1, 3'd2, 3'd3: fin = prod[PW-1:XLEN];
      3'd4:             fin = {{HW{prod[HW-1]}}, prod[HW-1:0]};
      default:          fin = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      result <= '0;
      cnt    <= '0;
      acc    <= '0;
      ma     <= '0;
      mb     <= '0;
      neg    <= 1'b0;
      op_q   <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          cnt  <= '0;
          acc  <= '0;
          ma   <= ld_a;
          mb   <= ld_b;
          neg  <= a_neg ^ b_neg;
          op_q <= op;
        end
      end else if (cnt == STEPS) begin
        busy   <= 1'b0;
        done   <= 1'b1;
        result <= fin;
      end else begin
        if (mb[0]) acc <= acc + ma;
        ma  <= ma << 1;
        mb  <= mb >> 1;
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

module rv64_mul_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic [2:0]      op,
  input logic            busy,
  input logic            done,
  input logic [XLEN-1:0] result
);
  localparam int TW = $clog2(XLEN + 3) + 1;
  logic [TW-1:0] age;
  logic [2:0]    op_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      age     <= '0;
      op_seen <= '0;
    end else if (start && !busy) begin
      age     <= TW'(1);
      op_seen <= op;
    end else if (age != '0) begin
      age <= age + 1'b1;
    end
  end

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  a_r7_latency:      assert property (@(posedge clk) disable iff (rst) done |-> age == TW'(XLEN + 2));
  a_r8_stays_busy:   assert property (@(posedge clk) disable iff (rst) (busy && start && !done) |=> (busy || done));
  a_r6_zero_codes:   assert property (@(posedge clk) disable iff (rst) (done && op_seen > 3'd4) |-> result == '0);
  a_r5_word_sext:    assert property (@(posedge clk) disable iff (rst)
                       (done && op_seen == 3'd4) |-> result[XLEN-1:XLEN/2] == {(XLEN/2){result[XLEN/2-1]}});
  a_r9_reset_clear:  assert property (@(posedge clk) rst |=> (!busy && !done && result == '0));
  a_r10_hold:        assert property (@(posedge clk) disable iff (rst) (!done && !$past(rst)) |-> $stable(result));
endmodule

bind rv64_mul_unit rv64_mul_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .start(start), .op(op),
  .busy(busy), .done(done), .result(result)
);

// File: tb/rv64_mul_unit_tb.sv
`timescale 1ns/100ps
module rv64_mul_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [63:0] src_a = '0, src_b = '0;
  logic        done;
  logic [63:0] result;

  int compared = 0, mismatched = 0;
  bit finished = 0;
  bit overlap = 0;

  always #2.5 clk = ~clk;

  rv64_mul_unit u_dut (
    .clk(clk), .rst(rst), .start(start), .op(op),
    .src_a(src_a), .src_b(src_b), .done(done), .result(result)
  );

  function automatic logic [63:0] ref_mul(input logic [2:0] c, input logic [63:0] a, input logic [63:0] b);
    logic [127:0] p;
    logic [31:0]  w;
    case (c)
      3'd0: ref_mul = a * b;
      3'd1: begin p = {{64{a[63]}}, a} * {{64{b[63]}}, b}; ref_mul = p[127:64]; end
      3'd2: begin p = {{64{a[63]}}, a} * {64'd0, b};       ref_mul = p[127:64]; end
      3'd3: begin p = {64'd0, a} * {64'd0, b};             ref_mul = p[127:64]; end
      3'd4: begin w = a[31:0] * b[31:0]; ref_mul = {{32{w[31]}}, w}; end
      default: ref_mul = 64'd0;
    endcase
  endfunction

  logic        m_busy, m_done;
  int          m_cnt;
  logic [63:0] m_res, m_pend;
  logic [2:0]  m_op;
  int          rst_win;

  always @(posedge clk) begin
    if (rst) begin
      m_busy <= 0; m_done <= 0; m_res <= 0; m_cnt <= 0; m_op <= 0; rst_win <= 3;
    end else begin
      if (rst_win > 0) rst_win <= rst_win - 1;
      m_done <= 0;
      if (m_busy) begin
        if (m_cnt == 1) begin m_busy <= 0; m_done <= 1; m_res <= m_pend; end
        m_cnt <= m_cnt - 1;
      end else if (start) begin
        m_busy <= 1; m_cnt <= 65; m_op <= op; m_pend <= ref_mul(op, src_a, src_b);
      end
    end
  end

  function automatic string res_tag(input logic [2:0] c);
    case (c)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  always @(negedge clk) begin
    if (!finished) begin
      string tr, td;
      tr = (rst || rst_win > 0) ? "R9" : (m_done ? res_tag(m_op) : "R10");
      td = (rst || rst_win > 0) ? "R9" : (overlap ? "R8" : "R7");
      compared++;
      if (done !== m_done) begin
        mismatched++;
        $display("FAIL %s done: actual %0b expected %0b at %0t", td, done, m_done, $time);
      end
      compared++;
      if (result !== m_res) begin
        mismatched++;
        $display("FAIL %s result: actual %h expected %h (op %0d) at %0t", tr, result, m_res, m_op, $time);
      end
    end
  end

  task automatic issue(input logic [2:0] c, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    start = 1'b1; op = c; src_a = a; src_b = b;
    @(negedge clk);
    start = 1'b0; src_a = $urandom; src_b = $urandom;
    while (m_busy || m_done) @(negedge clk);
    @(negedge clk);
  endtask

  localparam logic [63:0] MINV = 64'h8000_0000_0000_0000;
  localparam logic [63:0] MAXV = 64'h7fff_ffff_ffff_ffff;
  localparam logic [63:0] ONES = 64'hffff_ffff_ffff_ffff;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < 8; c++) begin
      issue(3'(c), 64'd0, 64'd5);
      issue(3'(c), MINV, ONES);
      issue(3'(c), ONES, ONES);
      issue(3'(c), MINV, MINV);
      issue(3'(c), MAXV, 64'd3);
      issue(3'(c), 64'hffff_ffff_8000_0000, 64'h0000_0001_7fff_ffff);
      issue(3'(c), {$urandom, $urandom}, {$urandom, $urandom});
      issue(3'(c), {$urandom, $urandom}, {$urandom, $urandom});
    end
    overlap = 1;
    @(negedge clk);
    start = 1; op = 3'd1; src_a = MINV; src_b = 64'd7;
    @(negedge clk);
    start = 0;
    repeat (10) @(negedge clk);
    start = 1; op = 3'd3; src_a = ONES; src_b = ONES;
    @(negedge clk);
    start = 1; op = 3'd0;
    @(negedge clk);
    start = 0;
    repeat (80) @(negedge clk);
    overlap = 0;
    @(negedge clk);
    start = 1; op = 3'd2; src_a = ONES; src_b = ONES;
    @(negedge clk);
    start = 0;
    repeat (20) @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    repeat (80) @(negedge clk);
    issue(3'd4, 64'h1234_5678_0000_ffff, 64'habcd_0000_0001_0001);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule